// File: doc/BRIEF.md
# SPI EEPROM Responder

This block lets a chip act as a small serial EEPROM on an SPI bus (mode 0). It samples the bus pins with its own system clock. A byte array held in flops stands in for the storage cells. A host drives chip select low, then sends a one-byte command. For memory commands an address follows, most significant byte first. The block returns data on the data-out pin.

Writes are staged in a one-page buffer. They reach the array only when chip select is released. Each committed write or status write is followed by a timed busy window, which models the programming time. A write-enable latch must be set before any change is accepted. Two block-protect bits fence off part of the array. A protect-enable bit, combined with a hardware protect input, can lock the protect bits. The `ADDR_BYTES` parameter sets the address length to 1, 2 or 3 bytes. The `OP_ADDR_BIT` parameter lets opcode bit 3 act as one extra top address bit.

Top module: `spi_ee_resp`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0x00, and `miso` is low.
- R2: A status read (opcode 0x05) returns bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = block-protect, bit 7 = protect-enable, and zeros in bits 6:4. Further bytes clocked in the same frame repeat the current status.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R4: A read (opcode 0x03) takes `ADDR_BYTES` address bytes, most significant first, then returns bytes from successive addresses for as long as `cs_n` stays low. The address wraps from the last byte of the array to address 0.
- R5: A write (0x02) or status write (0x01) issued while the write-enable latch is clear changes neither the array nor the status.
- R6: The write-enable latch clears when a write or status write commits.
- R7: During a write the address advances only within its `PAGE_BYTES`-aligned page, wrapping from the last byte of the page back to its first byte.
- R8: Write data is committed when `cs_n` rises. Only complete bytes are stored, and a trailing partial byte is dropped. For a status write, the last complete data byte supplies bits 7, 3 and 2.
- R9: After a commit the busy bit reads 1 for `BUSY_CYCLES` clock cycles. While busy, every opcode except 0x05 is ignored.
- R10: The block-protect bits select which bytes a write may not change. 00 protects none, 01 protects the upper quarter of the array, 10 the upper half, and 11 all of it.
- R11: While `wp_n` is low and the protect-enable bit is 1, a status write is ignored and the write-enable latch is left set. When `wp_n` is high the status write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| wp_n | input | 1 | Active-low hardware protect for the status register |
| miso | output | 1 | Serial data to the host; low when deselected |

## Verification
The assertions check the following on every cycle:
- A commit happens only while the write-enable latch is set.
- The latch is clear on the cycle after any commit.
- No array write lands while the busy timer runs.
- A new busy window never starts while one is running.
- Deselection always returns the command decoder to its opcode state.

Only the bench's scenarios can show the rest:
- The data values seen through the serial port, including page wrap and array-end wrap.
- The dropped partial byte.
- Which addresses each protect setting blocks.
- How long busy lasts.
- The hardware protect interlock.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADR,
        ST_RDAT,
        ST_WDAT,
        ST_SDAT,
        ST_RSTAT,
        ST_SKIP
    } ee_state_e;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // Region fenced off by the two protect bits.
    function automatic logic in_prot(input logic [1:0] bp, input logic [31:0] a,
                                     input logic [31:0] size);
        case (bp)
            2'd0:    return 1'b0;
            2'd1:    return a >= (size - size / 4);
            2'd2:    return a >= (size / 2);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic sel,
    output logic sel_end
);
    // bit 2 = sclk, bit 1 = mosi, bit 0 = cs_n
    logic [2:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 3'b001;
            s2_q <= 3'b001;
            s3_q <= 3'b001;
        end else begin
            s1_q <= {sclk, mosi, cs_n};
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign sel      = ~s2_q[0];
    assign sel_end  = s2_q[0] & ~s3_q[0];
    assign sck_rise = sel & s2_q[2] & ~s3_q[2];
    assign sck_fall = sel & ~s2_q[2] & s3_q[2];
    assign mosi_s   = s2_q[1];

endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
    parameter int unsigned BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9: the decoder never starts a new programming window while one runs
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
    parameter int unsigned MEM_BYTES  = 256,
    parameter int unsigned PAGE_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                 rd_data,
    input  logic                       wr_en,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0]      slot_en,
    input  logic [PAGE_BYTES-1:0][7:0] slot_data
);
    localparam int unsigned AW = $clog2(MEM_BYTES);
    localparam int unsigned PW = $clog2(PAGE_BYTES);
    localparam int unsigned GW = AW - PW;

    logic [7:0] cells [MEM_BYTES];

    for (genvar j = 0; j < MEM_BYTES; j++) begin : g_cell
        localparam int unsigned SLOT = j % PAGE_BYTES;
        localparam logic [GW-1:0] PG = GW'(j / PAGE_BYTES);
        logic [7:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= 8'h00;
            else if (wr_en && wr_page == PG && slot_en[SLOT])
                byte_q <= slot_data[SLOT];
        end

        assign cells[j] = byte_q;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/spi_ee_resp.sv
module spi_ee_resp
    import spi_ee_pkg::*;
#(
    parameter int unsigned MEM_BYTES   = 256,
    parameter int unsigned PAGE_BYTES  = 16,
    parameter int unsigned ADDR_BYTES  = 1,
    parameter bit          OP_ADDR_BIT = 1'b0,
    parameter int unsigned BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    input  logic wp_n,
    output logic miso
);
    localparam int unsigned AW  = $clog2(MEM_BYTES);
    localparam int unsigned PW  = $clog2(PAGE_BYTES);
    localparam int unsigned AB8 = 8 * ADDR_BYTES;

    typedef struct packed {
        ee_state_e                st;
        logic [2:0]               bitc;
        logic [7:0]               rx;
        logic [7:0]               tx;
        logic [1:0]               abyte;
        logic                     rd_cmd;
        logic                     xb;
        logic [AB8-1:0]           acc;
        logic [AW-1:0]            ptr;
        logic                     wel;
        logic [1:0]               bp;
        logic                     wpen;
        logic [7:0]               sstage;
        logic                     spend;
        logic [PAGE_BYTES-1:0]    vld;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
    } ee_regs_t;

    ee_regs_t r_d, r_q;

    logic sck_rise, sck_fall, mosi_s, sel, sel_end;
    logic busy, start, mem_we;
    logic [7:0] byte_in, op_m, rd_data, stat_now;
    logic [AB8-1:0] acc_in;
    logic [AW-1:0] tgt, rd_addr;
    logic [PW-1:0] slot, slot_nx;
    logic [PAGE_BYTES-1:0] prot_m;

    spi_ee_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .sel(sel), .sel_end(sel_end)
    );

    spi_ee_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    spi_ee_mem #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(mem_we), .wr_page(r_q.ptr[AW-1:PW]),
        .slot_en(r_q.vld & ~prot_m), .slot_data(r_q.pbuf)
    );

    // Values the decoder needs on the completing edge of a byte
    assign byte_in  = {r_q.rx[6:0], mosi_s};
    assign acc_in   = AB8'({r_q.acc, byte_in});
    assign tgt      = AW'({r_q.xb, acc_in});
    assign rd_addr  = (r_q.st == ST_ADR) ? tgt : r_q.ptr;
    assign slot     = r_q.ptr[PW-1:0];
    assign slot_nx  = slot + PW'(1);
    assign stat_now = {r_q.wpen, 3'b000, r_q.bp, r_q.wel, busy};

    always_comb begin
        for (int s = 0; s < PAGE_BYTES; s++)
            prot_m[s] = in_prot(r_q.bp, 32'({r_q.ptr[AW-1:PW], PW'(s)}), 32'(MEM_BYTES));
    end

    always_comb begin
        r_d    = r_q;
        start  = 1'b0;
        mem_we = 1'b0;
        op_m   = byte_in;
        if (OP_ADDR_BIT) op_m[3] = 1'b0;

        if (!sel) begin
            r_d.st   = ST_OPC;
            r_d.bitc = '0;
            if (sel_end) begin
                if (r_q.st == ST_WDAT && |r_q.vld) begin
                    mem_we  = 1'b1;
                    start   = 1'b1;
                    r_d.wel = 1'b0;
                    r_d.vld = '0;
                end
                if (r_q.st == ST_SDAT && r_q.spend) begin
                    r_d.bp    = r_q.sstage[3:2];
                    r_d.wpen  = r_q.sstage[7];
                    r_d.spend = 1'b0;
                    r_d.wel   = 1'b0;
                    start     = 1'b1;
                end
            end
        end else begin
            if (sck_fall && r_q.bitc != '0)
                r_d.tx = {r_q.tx[6:0], 1'b0};
            if (sck_rise) begin
                r_d.rx   = byte_in;
                r_d.bitc = r_q.bitc + 3'd1;
                if (r_q.bitc == 3'd7) begin
                    unique case (r_q.st)
                        ST_OPC: begin
                            r_d.st = ST_SKIP;
                            r_d.xb = OP_ADDR_BIT ? byte_in[3] : 1'b0;
                            if (!busy || op_m == OP_RSTAT) begin
                                case (op_m)
                                    OP_WEN:   r_d.wel = 1'b1;
                                    OP_WDIS:  r_d.wel = 1'b0;
                                    OP_RSTAT: begin
                                        r_d.tx = stat_now;
                                        r_d.st = ST_RSTAT;
                                    end
                                    OP_WSTAT: if (r_q.wel && !(!wp_n && r_q.wpen)) begin
                                        r_d.st    = ST_SDAT;
                                        r_d.spend = 1'b0;
                                    end
                                    OP_READ, OP_WRITE: if (op_m == OP_READ || r_q.wel) begin
                                        r_d.st     = ST_ADR;
                                        r_d.rd_cmd = (op_m == OP_READ);
                                        r_d.abyte  = '0;
                                        r_d.acc    = '0;
                                        r_d.vld    = '0;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                        ST_ADR: begin
                            r_d.acc = acc_in;
                            if (r_q.abyte == 2'(ADDR_BYTES - 1)) begin
                                if (r_q.rd_cmd) begin
                                    r_d.tx  = rd_data;
                                    r_d.ptr = tgt + AW'(1);
                                    r_d.st  = ST_RDAT;
                                end else begin
                                    r_d.ptr = tgt;
                                    r_d.st  = ST_WDAT;
                                end
                            end else begin
                                r_d.abyte = r_q.abyte + 2'd1;
                            end
                        end
                        ST_RDAT: begin
                            r_d.tx  = rd_data;
                            r_d.ptr = r_q.ptr + AW'(1);
                        end
                        ST_WDAT: begin
                            r_d.pbuf[slot] = byte_in;
                            r_d.vld[slot]  = 1'b1;
                            r_d.ptr        = {r_q.ptr[AW-1:PW], slot_nx};
                        end
                        ST_SDAT: begin
                            r_d.sstage = byte_in;
                            r_d.spend  = 1'b1;
                        end
                        ST_RSTAT: r_d.tx = stat_now;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_OPC;
        end else begin
            r_q <= r_d;
        end
    end

    assign miso = sel & r_q.tx[7];

    // R5: nothing commits unless the latch was set
    p_wel_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> r_q.wel);

    // R6: latch is clear right after a commit
    p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !r_q.wel);

    // R9: the array is never written during a programming window
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    // R4: a frame ends when chip select is released
    p_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (r_q.st == ST_OPC && r_q.bitc == 3'd0));

endmodule

// File: tb/spi_ee_resp_tb.sv
`timescale 1ns/100ps
module spi_ee_resp_tb;

    localparam int MEM  = 256;
    localparam int PAGE = 16;
    localparam int HALF = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
    logic miso;

    int total = 0, bad = 0;
    logic [7:0] mdl [MEM];
    bit m_wel = 0, m_wpen = 0;
    bit [1:0] m_bp = 0;
    logic [7:0] wb [32];
    logic [7:0] rb [32];
    logic [7:0] st;

    always #2.5 clk = ~clk;

    spi_ee_resp #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .ADDR_BYTES(1),
                  .OP_ADDR_BIT(1'b0), .BUSY_CYCLES(300)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .wp_n(wp_n), .miso(miso));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit m_prot(input int a);
        case (m_bp)
            2'd0: return 0;
            2'd1: return a >= MEM - MEM / 4;
            2'd2: return a >= MEM / 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_stat();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            #HALF;
            r[i] = miso;
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic sel_off();
        #HALF;
        cs_n = 1'b1;
        #60;
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel_on(); xfer(op, d); sel_off();
    endtask

    task automatic wren();
        cmd1(8'h06);
        m_wel = 1;
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel_on(); xfer(8'h05, d); xfer(8'h00, s); sel_off();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        bit done = 0;
        for (int k = 0; k < 40 && !done; k++) begin
            rdsr(s);
            if (!s[0]) done = 1;
        end
        chk("R9 busy ends", 32'(done), 32'd1);
    endtask

    task automatic ee_write(input int a, input int n, input int tail_bits);
        logic [7:0] d;
        sel_on();
        xfer(8'h02, d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(wb[k], d);
        for (int k = 0; k < tail_bits; k++) begin
            mosi = 1'b1; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
        end
        sel_off();
        if (m_wel && n > 0) begin
            for (int k = 0; k < n; k++) begin
                int ad;
                ad = (a & ~(PAGE - 1)) | ((a + k) & (PAGE - 1));
                if (!m_prot(ad)) mdl[ad] = wb[k];
            end
            m_wel = 0;
        end
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel_on(); xfer(8'h01, d); xfer(v, d); sel_off();
        if (m_wel && !(!wp_n && m_wpen)) begin
            m_bp = v[3:2];
            m_wpen = v[7];
            m_wel = 0;
        end
    endtask

    task automatic ee_read(input int a, input int n);
        logic [7:0] d;
        sel_on();
        xfer(8'h03, d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(8'h00, rb[k]);
        sel_off();
    endtask

    task automatic check_read(input string req, input int a, input int n);
        ee_read(a, n);
        for (int k = 0; k < n; k++) chk(req, rb[k], mdl[(a + k) % MEM]);
    endtask

    task automatic check_stat(input string req);
        rdsr(st);
        chk(req, st, exp_stat());
    endtask

    initial begin
        #(150000 * 5);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < MEM; i++) mdl[i] = 8'h00;
        void'($urandom(32'd4242));
        #51;
        rst_n = 1'b1;
        #40;

        // R1: reset state
        chk("R1 miso idle", 32'(miso), 32'd0);
        check_stat("R1 status");
        check_read("R1 array", 8'h00, 8);

        // R3 / R2
        wren();
        check_stat("R3 latch set");
        sel_on(); xfer(8'h05, d); xfer(8'h00, st); xfer(8'h00, d); sel_off();
        chk("R2 status first byte", st, 8'h02);
        chk("R2 status repeat", d, 8'h02);
        cmd1(8'h04); m_wel = 0;
        check_stat("R3 latch clear");

        // R5: write without latch
        wb[0] = 8'hA5;
        ee_write(8'h10, 1, 0);
        check_read("R5 write ignored", 8'h10, 1);
        wrsr(8'h0C);
        check_stat("R5 status write ignored");

        // R6 / R9: write, busy, latch cleared, ops ignored while busy
        wren();
        wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
        ee_write(8'h10, 4, 0);
        rdsr(st);
        chk("R9 busy reported", st, 8'h01);
        chk("R6 latch cleared", 32'(st[1]), 32'd0);
        cmd1(8'h06);
        wait_idle();
        check_stat("R9 opcode ignored while busy");
        check_read("R4 read back", 8'h10, 4);

        // R7: page wrap
        wren();
        for (int k = 0; k < 6; k++) wb[k] = 8'hB0 + 8'(k);
        ee_write(8'h1C, 6, 0);
        wait_idle();
        check_read("R7 page wrap", 8'h0F, 18);
        chk("R7 wrapped byte", mdl[8'h10], 8'hB4);

        // R8: partial trailing byte
        wren();
        wb[0] = 8'hC1; wb[1] = 8'hC2;
        ee_write(8'h40, 2, 3);
        wait_idle();
        check_read("R8 partial dropped", 8'h40, 3);
        chk("R8 third byte", rb[2], 8'h00);

        // R4: stream wraps at end of array
        wren();
        wb[0] = 8'hE1; wb[1] = 8'hE2;
        ee_write(8'hFE, 2, 0);
        wait_idle();
        check_read("R4 array wrap", 8'hFE, 5);

        // R10: protect regions
        wren(); wrsr(8'h04); wait_idle();
        check_stat("R10 bp quarter");
        wren(); wb[0] = 8'h5A; ee_write(8'hC0, 1, 0); wait_idle();
        wren(); wb[0] = 8'h5B; ee_write(8'hBF, 1, 0); wait_idle();
        check_read("R10 quarter", 8'hBE, 4);
        chk("R10 quarter blocked", rb[2], 8'h00);
        wren(); wrsr(8'h08); wait_idle();
        wren(); wb[0] = 8'h6A; ee_write(8'h80, 1, 0); wait_idle();
        wren(); wb[0] = 8'h6B; ee_write(8'h7F, 1, 0); wait_idle();
        check_read("R10 half", 8'h7F, 2);
        wren(); wrsr(8'h0C); wait_idle();
        wren(); wb[0] = 8'h7A; ee_write(8'h00, 1, 0); wait_idle();
        check_read("R10 all", 8'h00, 1);

        // R11: hardware protect interlock
        wren(); wrsr(8'h8C); wait_idle();
        check_stat("R11 wpen set");
        wp_n = 1'b0;
        wren(); wrsr(8'h00);
        rdsr(st);
        chk("R11 locked", st, 8'h8E);
        wp_n = 1'b1;
        wrsr(8'h00); wait_idle();
        check_stat("R11 unlocked");
        chk("R11 cleared", st, 8'h00);

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int kind, a, n;
            kind = $urandom % 3;
            a = $urandom % MEM;
            n = 1 + $urandom % 20;
            if (kind == 0) begin
                for (int k = 0; k < n; k++) wb[k] = 8'($urandom);
                wren(); ee_write(a, n, 0); wait_idle();
            end else if (kind == 1) begin
                check_read("R4 random read", a, n);
            end else begin
                wren(); wrsr({4'b0000, 2'($urandom), 2'b00}); wait_idle();
                check_stat("R10 random bp");
            end
        end
        wren(); wrsr(8'h00); wait_idle();
        for (int p = 0; p < MEM; p += 32) check_read("R7 final image", p, 32);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule